// File: doc/BRIEF.md
# Load-Use Stall and Branch Penalty Tracker

This block sits beside the issue stage of a single-issue core and accounts for the timing of each instruction. The instruction's real register reads and memory traffic happen elsewhere. Each issued instruction arrives with a class code, two source register fields, a destination register, a taken flag, a delay-slot flag and a base latency. The block returns the stall cycles the instruction costs and the instruction's total cycle count. It also keeps running totals of cycles, load-use stalls, control-transfer stalls, and taken and untaken control transfers.

Hazards are tracked with a two-stage scoreboard. While an instruction is being accounted, a fresh "recent loads" mask is built. It holds one bit, the destination of a load, or nothing. When the instruction retires, that mask becomes the active mask, and the following instruction is checked against it. A scoreboard state machine has two named states. `SB_EMPTY` means no load is outstanding. `SB_ARMED` means the active mask holds a load destination. On every issue the transition is `SB_EMPTY -> SB_ARMED` or `SB_ARMED -> SB_ARMED` when the issuing instruction is a load, and `SB_ARMED -> SB_EMPTY` or `SB_EMPTY -> SB_EMPTY` otherwise. A synchronous clear forces `SB_EMPTY`. Cycles without an issue keep the state.

Class encoding on `op_class`: 0 execute, 1 control transfer, 2 load, 3 store, 4 load-multiple, 5 store-multiple. Codes 6 and 7 are accounted like load-multiple. A source field is `IDX_W+1` bits wide. When its top bit is 1 the source is absent ("none"); otherwise the low `IDX_W` bits name the register.

Top module: `load_use_tracker`

## Requirements
- R1: While `clr` is high at a clock edge, the scoreboard is emptied and every counter, `cur_stalls` and `cur_cycles` become zero at that edge.
- R2: A load sets the bit of its `dst` register. Each checked source of the next instruction that names that register adds one stall cycle and adds one to `load_stalls`, so a register named in both sources costs two.
- R3: Only the instruction issued right after a load sees the load's destination, because every issue replaces the active mask. Cycles with `issue` low change no mask, no counter and no latched output.
- R4: A source field whose top bit is 1 never causes a stall, whatever its low bits hold.
- R5: Execute (0) and store (3) check both `src_a` and `src_b`. Load (2) checks only `src_a`, its address base. Control transfer (1) checks only `src_a`.
- R6: Load-multiple (4), store-multiple (5) and the unused codes 6 and 7 perform no hazard check, so their cycle count equals `base_lat`.
- R7: A control transfer with `taken`=1 and `delay_slot`=0 adds one cycle and adds one to `cti_stalls`. With `delay_slot`=1 it adds nothing.
- R8: A control transfer adds one to `taken_cnt` when `taken`=1 and one to `untaken_cnt` otherwise. Other classes leave both counters alone.
- R9: An instruction's cycle count is `base_lat` plus its stalls. It is latched on `cur_cycles`, with the stalls on `cur_stalls`, at the issuing edge, and is added to `tot_cycles`.
- R10: All counters are `CNT_W` bits wide and wrap modulo 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| issue | input | 1 | An instruction is accounted at this edge |
| op_class | input | 3 | Instruction class code |
| src_a | input | IDX_W+1 | First source; top bit set means none |
| src_b | input | IDX_W+1 | Second source; top bit set means none |
| dst | input | IDX_W | Destination register of a load |
| taken | input | 1 | Control transfer is taken |
| delay_slot | input | 1 | Control transfer has a delay slot |
| base_lat | input | LAT_W | Base latency of the instruction |
| cur_stalls | output | 2 | Stall cycles of the last issued instruction |
| cur_cycles | output | LAT_W+2 | Cycle count of the last issued instruction |
| tot_cycles | output | CNT_W | Running cycle total |
| load_stalls | output | CNT_W | Running load-use stall count |
| cti_stalls | output | CNT_W | Running control-transfer stall count |
| taken_cnt | output | CNT_W | Running count of taken control transfers |
| untaken_cnt | output | CNT_W | Running count of untaken control transfers |

## Verification
The bench builds the block with 16 registers and a 4-bit base latency, so the largest cycle count of 17 is exercised on the 6-bit `cur_cycles`. It narrows the counters to 8 bits. With that width, eighteen instructions of latency 15 carry `tot_cycles` past 255, and the wrap of R10 is checked without billions of cycles. Directed sequences place a load before consumers of each class, with idle gaps and intervening instructions, to probe the one-instruction hazard window.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic [2:0] {
        CLS_EXEC  = 3'd0,
        CLS_CTI   = 3'd1,
        CLS_LOAD  = 3'd2,
        CLS_STORE = 3'd3,
        CLS_LDM   = 3'd4,
        CLS_STM   = 3'd5
    } op_class_e;

    typedef enum logic {
        SB_EMPTY = 1'b0,
        SB_ARMED = 1'b1
    } sb_state_e;

    localparam int NUM_CNT = 5;
    localparam int CNT_TOT = 0;
    localparam int CNT_LDS = 1;
    localparam int CNT_CTS = 2;
    localparam int CNT_TKN = 3;
    localparam int CNT_UTK = 4;

endpackage

// File: rtl/ptt_scoreboard.sv
module ptt_scoreboard
    import ptt_pkg::*;
#(
    parameter int NREGS = 16
) (
    input  logic                     clk,
    input  logic                     clr,
    input  logic                     issue,
    input  logic                     is_load,
    input  logic [$clog2(NREGS)-1:0] dst,
    input  logic [$clog2(NREGS):0]   src_a,
    input  logic [$clog2(NREGS):0]   src_b,
    output logic                     hit_a,
    output logic                     hit_b
);
    localparam int IDX_W = $clog2(NREGS);
    localparam int SRC_W = IDX_W + 1;

    sb_state_e        state_q;
    sb_state_e        state_d;
    logic [NREGS-1:0] active_q;
    logic [NREGS-1:0] pend_mask;

    // Mask gathered during the current instruction: starts empty, a load adds its destination.
    always_comb begin
        pend_mask = '0;
        if (is_load) begin
            pend_mask[dst] = 1'b1;
        end
    end

    // Next-state selection, taken only when an instruction retires.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_EMPTY: state_d = is_load ? SB_ARMED : SB_EMPTY;
            SB_ARMED: state_d = is_load ? SB_ARMED : SB_EMPTY;
            default:  state_d = SB_EMPTY;
        endcase
    end

    // State register and active mask.
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q  <= SB_EMPTY;
            active_q <= '0;
        end else if (issue) begin
            state_q  <= state_d;
            active_q <= pend_mask;
        end
    end

    // Hazard outputs derived from the state.
    always_comb begin
        hit_a = 1'b0;
        hit_b = 1'b0;
        unique case (state_q)
            SB_EMPTY: begin
                hit_a = 1'b0;
                hit_b = 1'b0;
            end
            SB_ARMED: begin
                hit_a = !src_a[SRC_W-1] && active_q[src_a[IDX_W-1:0]];
                hit_b = !src_b[SRC_W-1] && active_q[src_b[IDX_W-1:0]];
            end
            default: begin
                hit_a = 1'b0;
                hit_b = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ptt_cycle_calc.sv
module ptt_cycle_calc
    import ptt_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic [2:0]       op_class,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic             taken,
    input  logic             delay_slot,
    input  logic [LAT_W-1:0] base_lat,
    output logic             is_load,
    output logic [1:0]       ld_stall_n,
    output logic             cti_pen,
    output logic             tkn_ev,
    output logic             utk_ev,
    output logic [1:0]       stalls,
    output logic [LAT_W+1:0] cycles
);
    localparam int CYC_W = LAT_W + 2;

    logic use_a;
    logic use_b;
    logic is_cti;

    // Which operands each class inspects.
    always_comb begin
        use_a   = 1'b0;
        use_b   = 1'b0;
        is_cti  = 1'b0;
        is_load = 1'b0;
        unique case (op_class_e'(op_class))
            CLS_EXEC: begin
                use_a = 1'b1;
                use_b = 1'b1;
            end
            CLS_STORE: begin
                use_a = 1'b1;
                use_b = 1'b1;
            end
            CLS_LOAD: begin
                use_a   = 1'b1;
                is_load = 1'b1;
            end
            CLS_CTI: begin
                use_a  = 1'b1;
                is_cti = 1'b1;
            end
            default: begin
                use_a = 1'b0;
                use_b = 1'b0;
            end
        endcase
    end

    always_comb begin
        ld_stall_n = {1'b0, use_a & hit_a} + {1'b0, use_b & hit_b};
        cti_pen    = is_cti & taken & !delay_slot;
        tkn_ev     = is_cti & taken;
        utk_ev     = is_cti & !taken;
        stalls     = ld_stall_n + {1'b0, cti_pen};
        cycles     = CYC_W'(base_lat) + CYC_W'(stalls);
    end

endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
    parameter int W     = 32,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     q
);
    always_ff @(posedge clk) begin
        if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= q + W'(inc);
        end
    end
endmodule

// File: rtl/load_use_tracker.sv
module load_use_tracker
    import ptt_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int LAT_W = 4,
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     clr,
    input  logic                     issue,
    input  logic [2:0]               op_class,
    input  logic [$clog2(NREGS):0]   src_a,
    input  logic [$clog2(NREGS):0]   src_b,
    input  logic [$clog2(NREGS)-1:0] dst,
    input  logic                     taken,
    input  logic                     delay_slot,
    input  logic [LAT_W-1:0]         base_lat,
    output logic [1:0]               cur_stalls,
    output logic [LAT_W+1:0]         cur_cycles,
    output logic [CNT_W-1:0]         tot_cycles,
    output logic [CNT_W-1:0]         load_stalls,
    output logic [CNT_W-1:0]         cti_stalls,
    output logic [CNT_W-1:0]         taken_cnt,
    output logic [CNT_W-1:0]         untaken_cnt
);
    localparam int CYC_W = LAT_W + 2;

    logic             hit_a;
    logic             hit_b;
    logic             is_load;
    logic [1:0]       ld_stall_n;
    logic             cti_pen;
    logic             tkn_ev;
    logic             utk_ev;
    logic [1:0]       stalls;
    logic [CYC_W-1:0] cycles;

    logic [NUM_CNT-1:0]            cnt_en;
    logic [NUM_CNT-1:0][CYC_W-1:0] cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    ptt_scoreboard #(.NREGS(NREGS)) u_sb (
        .clk     (clk),
        .clr     (clr),
        .issue   (issue),
        .is_load (is_load),
        .dst     (dst),
        .src_a   (src_a),
        .src_b   (src_b),
        .hit_a   (hit_a),
        .hit_b   (hit_b)
    );

    ptt_cycle_calc #(.LAT_W(LAT_W)) u_calc (
        .op_class   (op_class),
        .hit_a      (hit_a),
        .hit_b      (hit_b),
        .taken      (taken),
        .delay_slot (delay_slot),
        .base_lat   (base_lat),
        .is_load    (is_load),
        .ld_stall_n (ld_stall_n),
        .cti_pen    (cti_pen),
        .tkn_ev     (tkn_ev),
        .utk_ev     (utk_ev),
        .stalls     (stalls),
        .cycles     (cycles)
    );

    // Counter enables and increments.
    always_comb begin
        cnt_en           = '0;
        cnt_inc          = '0;
        cnt_en[CNT_TOT]  = issue;
        cnt_inc[CNT_TOT] = cycles;
        cnt_en[CNT_LDS]  = issue;
        cnt_inc[CNT_LDS] = CYC_W'(ld_stall_n);
        cnt_en[CNT_CTS]  = issue & cti_pen;
        cnt_inc[CNT_CTS] = CYC_W'(1);
        cnt_en[CNT_TKN]  = issue & tkn_ev;
        cnt_inc[CNT_TKN] = CYC_W'(1);
        cnt_en[CNT_UTK]  = issue & utk_ev;
        cnt_inc[CNT_UTK] = CYC_W'(1);
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        ptt_counter #(.W(CNT_W), .INC_W(CYC_W)) u_cnt (
            .clk (clk),
            .clr (clr),
            .en  (cnt_en[gi]),
            .inc (cnt_inc[gi]),
            .q   (cnt_q[gi])
        );
    end

    // Latched result of the last issued instruction.
    always_ff @(posedge clk) begin
        if (clr) begin
            cur_stalls <= '0;
            cur_cycles <= '0;
        end else if (issue) begin
            cur_stalls <= stalls;
            cur_cycles <= cycles;
        end
    end

    assign tot_cycles  = cnt_q[CNT_TOT];
    assign load_stalls = cnt_q[CNT_LDS];
    assign cti_stalls  = cnt_q[CNT_CTS];
    assign taken_cnt   = cnt_q[CNT_TKN];
    assign untaken_cnt = cnt_q[CNT_UTK];

endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
    parameter int NREGS = 16,
    parameter int LAT_W = 4,
    parameter int CNT_W = 32
) (
    input logic                   clk,
    input logic                   clr,
    input logic                   issue,
    input logic [2:0]             op_class,
    input logic [$clog2(NREGS):0] src_a,
    input logic [$clog2(NREGS):0] src_b,
    input logic                   taken,
    input logic                   delay_slot,
    input logic [LAT_W-1:0]       base_lat,
    input logic [1:0]             cur_stalls,
    input logic [LAT_W+1:0]       cur_cycles,
    input logic [CNT_W-1:0]       tot_cycles,
    input logic [CNT_W-1:0]       load_stalls,
    input logic [CNT_W-1:0]       cti_stalls,
    input logic [CNT_W-1:0]       taken_cnt,
    input logic [CNT_W-1:0]       untaken_cnt
);
    localparam int SRC_W = $clog2(NREGS) + 1;

    a_r1_clear_zero: assert property (@(posedge clk)
        clr |=> (tot_cycles == '0) && (load_stalls == '0) && (cti_stalls == '0)
                && (taken_cnt == '0) && (untaken_cnt == '0)
                && (cur_cycles == '0) && (cur_stalls == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (clr)
        !issue |=> $stable(tot_cycles) && $stable(load_stalls) && $stable(cur_cycles)
                   && $stable(cur_stalls) && $stable(taken_cnt) && $stable(untaken_cnt));

    a_r4_none_no_stall: assert property (@(posedge clk) disable iff (clr)
        (issue && op_class != 3'd1 && src_a[SRC_W-1] && src_b[SRC_W-1])
        |=> (cur_stalls == 2'd0) && (load_stalls == $past(load_stalls)));

    a_r6_multi_base_only: assert property (@(posedge clk) disable iff (clr)
        (issue && op_class >= 3'd4)
        |=> (cur_stalls == 2'd0) && (cur_cycles == (LAT_W+2)'($past(base_lat))));

    a_r7_cti_penalty: assert property (@(posedge clk) disable iff (clr)
        (issue && op_class == 3'd1 && taken && !delay_slot)
        |=> cti_stalls == $past(cti_stalls) + CNT_W'(1));

    a_r8_non_cti_quiet: assert property (@(posedge clk) disable iff (clr)
        (issue && op_class != 3'd1) |=> $stable(taken_cnt) && $stable(untaken_cnt));

    a_r9_total_accum: assert property (@(posedge clk) disable iff (clr)
        issue |=> tot_cycles == $past(tot_cycles) + CNT_W'(cur_cycles));
endmodule

bind load_use_tracker ptt_checker #(
    .NREGS(NREGS),
    .LAT_W(LAT_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .clr         (clr),
    .issue       (issue),
    .op_class    (op_class),
    .src_a       (src_a),
    .src_b       (src_b),
    .taken       (taken),
    .delay_slot  (delay_slot),
    .base_lat    (base_lat),
    .cur_stalls  (cur_stalls),
    .cur_cycles  (cur_cycles),
    .tot_cycles  (tot_cycles),
    .load_stalls (load_stalls),
    .cti_stalls  (cti_stalls),
    .taken_cnt   (taken_cnt),
    .untaken_cnt (untaken_cnt)
);

// File: tb/load_use_tracker_tb.sv
module load_use_tracker_tb;
    localparam int NREGS = 16;
    localparam int LAT_W = 4;
    localparam int CNT_W = 8;
    localparam int IDX_W = 4;
    localparam logic [IDX_W:0] NONE = 5'b10000;

    logic             clk = 1'b0;
    logic             clr = 1'b1;
    logic             issue = 1'b0;
    logic [2:0]       op_class = 3'd0;
    logic [IDX_W:0]   src_a = NONE;
    logic [IDX_W:0]   src_b = NONE;
    logic [IDX_W-1:0] dst = '0;
    logic             taken = 1'b0;
    logic             delay_slot = 1'b0;
    logic [LAT_W-1:0] base_lat = '0;
    logic [1:0]       cur_stalls;
    logic [LAT_W+1:0] cur_cycles;
    logic [CNT_W-1:0] tot_cycles, load_stalls, cti_stalls, taken_cnt, untaken_cnt;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    load_use_tracker #(.NREGS(NREGS), .LAT_W(LAT_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .clr(clr), .issue(issue), .op_class(op_class),
        .src_a(src_a), .src_b(src_b), .dst(dst), .taken(taken),
        .delay_slot(delay_slot), .base_lat(base_lat),
        .cur_stalls(cur_stalls), .cur_cycles(cur_cycles),
        .tot_cycles(tot_cycles), .load_stalls(load_stalls),
        .cti_stalls(cti_stalls), .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Drives one instruction at the current negedge and returns at the next negedge.
    task automatic op(input logic [2:0] c, input logic [IDX_W:0] a, input logic [IDX_W:0] b,
                      input int d, input logic tk, input logic ds, input int lat);
        issue = 1'b1; op_class = c; src_a = a; src_b = b; dst = IDX_W'(d);
        taken = tk; delay_slot = ds; base_lat = LAT_W'(lat);
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    function automatic logic [IDX_W:0] r(input int i);
        return {1'b0, IDX_W'(i)};
    endfunction

    task automatic t_reset();
        do_clear();
        chk("R1", "tot_cycles", int'(tot_cycles), 0);
        chk("R1", "load_stalls", int'(load_stalls), 0);
        chk("R1", "cti_stalls", int'(cti_stalls), 0);
        chk("R1", "taken_cnt", int'(taken_cnt), 0);
        chk("R1", "untaken_cnt", int'(untaken_cnt), 0);
        chk("R1", "cur_cycles", int'(cur_cycles), 0);
    endtask

    task automatic t_basic();
        do_clear();
        op(3'd0, r(1), r(2), 0, 1'b0, 1'b0, 3);
        chk("R9", "exec cur_cycles", int'(cur_cycles), 3);
        chk("R9", "exec tot_cycles", int'(tot_cycles), 3);
        @(negedge clk);
        chk("R3", "idle keeps cur_cycles", int'(cur_cycles), 3);
    endtask

    task automatic t_load_use();
        do_clear();
        op(3'd2, r(0), NONE, 3, 1'b0, 1'b0, 2);
        op(3'd0, r(3), r(3), 0, 1'b0, 1'b0, 1);
        chk("R2", "double hit stalls", int'(cur_stalls), 2);
        chk("R2", "load_stalls", int'(load_stalls), 2);
        chk("R9", "cur_cycles with stalls", int'(cur_cycles), 3);
        chk("R9", "tot_cycles", int'(tot_cycles), 5);
        op(3'd2, r(0), NONE, 4, 1'b0, 1'b0, 1);
        op(3'd3, r(1), r(4), 0, 1'b0, 1'b0, 1);
        chk("R5", "store checks src_b", int'(cur_stalls), 1);
    endtask

    task automatic t_window();
        do_clear();
        op(3'd2, r(0), NONE, 6, 1'b0, 1'b0, 1);
        op(3'd0, r(7), NONE, 0, 1'b0, 1'b0, 1);
        op(3'd0, r(6), r(6), 0, 1'b0, 1'b0, 1);
        chk("R3", "hazard gone after one instr", int'(cur_stalls), 0);
        op(3'd2, r(0), NONE, 6, 1'b0, 1'b0, 1);
        repeat (3) @(negedge clk);
        op(3'd0, r(6), NONE, 0, 1'b0, 1'b0, 1);
        chk("R3", "idle gap keeps hazard", int'(cur_stalls), 1);
    endtask

    task automatic t_none();
        do_clear();
        op(3'd2, r(0), NONE, 5, 1'b0, 1'b0, 1);
        op(3'd0, NONE | 5'd5, NONE, 0, 1'b0, 1'b0, 1);
        chk("R4", "none source no stall", int'(cur_stalls), 0);
        chk("R4", "load_stalls unchanged", int'(load_stalls), 0);
    endtask

    task automatic t_class_sel();
        do_clear();
        op(3'd2, r(0), NONE, 8, 1'b0, 1'b0, 1);
        op(3'd2, r(1), r(8), 9, 1'b0, 1'b0, 1);
        chk("R5", "load ignores src_b", int'(cur_stalls), 0);
        op(3'd2, r(9), NONE, 8, 1'b0, 1'b0, 1);
        chk("R5", "load checks base src_a", int'(cur_stalls), 1);
        op(3'd1, r(8), NONE, 0, 1'b0, 1'b0, 2);
        chk("R5", "cti checks src_a", int'(cur_stalls), 1);
        chk("R8", "untaken_cnt", int'(untaken_cnt), 1);
    endtask

    task automatic t_multi();
        do_clear();
        op(3'd2, r(0), NONE, 9, 1'b0, 1'b0, 1);
        op(3'd4, r(9), r(9), 0, 1'b0, 1'b0, 4);
        chk("R6", "ldm cycles", int'(cur_cycles), 4);
        op(3'd2, r(0), NONE, 9, 1'b0, 1'b0, 1);
        op(3'd5, r(9), r(9), 0, 1'b0, 1'b0, 5);
        chk("R6", "stm cycles", int'(cur_cycles), 5);
        op(3'd2, r(0), NONE, 9, 1'b0, 1'b0, 1);
        op(3'd7, r(9), r(9), 0, 1'b0, 1'b0, 6);
        chk("R6", "code 7 cycles", int'(cur_cycles), 6);
        chk("R6", "load_stalls", int'(load_stalls), 0);
    endtask

    task automatic t_cti();
        do_clear();
        op(3'd1, NONE, NONE, 0, 1'b1, 1'b0, 2);
        chk("R7", "taken no slot cycles", int'(cur_cycles), 3);
        chk("R7", "cti_stalls", int'(cti_stalls), 1);
        op(3'd1, NONE, NONE, 0, 1'b1, 1'b1, 2);
        chk("R7", "taken with slot cycles", int'(cur_cycles), 2);
        chk("R7", "cti_stalls with slot", int'(cti_stalls), 1);
        chk("R8", "taken_cnt", int'(taken_cnt), 2);
        op(3'd1, NONE, NONE, 0, 1'b0, 1'b0, 2);
        chk("R8", "untaken_cnt", int'(untaken_cnt), 1);
        op(3'd0, NONE, NONE, 0, 1'b1, 1'b0, 1);
        chk("R8", "exec leaves taken_cnt", int'(taken_cnt), 2);
        op(3'd2, r(0), NONE, 2, 1'b0, 1'b0, 15);
        op(3'd1, r(2), NONE, 0, 1'b1, 1'b0, 15);
        chk("R9", "max cycle count", int'(cur_cycles), 17);
    endtask

    task automatic t_wrap();
        do_clear();
        for (int i = 0; i < 18; i++) op(3'd0, NONE, NONE, 0, 1'b0, 1'b0, 15);
        chk("R10", "tot_cycles wraps", int'(tot_cycles), 14);
    endtask

    task automatic t_clear_mask();
        do_clear();
        op(3'd2, r(0), NONE, 5, 1'b0, 1'b0, 1);
        do_clear();
        op(3'd0, r(5), NONE, 0, 1'b0, 1'b0, 1);
        chk("R1", "clear empties scoreboard", int'(cur_stalls), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_load_use();
        t_window();
        t_none();
        t_class_sel();
        t_multi();
        t_cti();
        t_wrap();
        t_clear_mask();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule